// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the device-side control logic of a small byte-wide nonvolatile memory model. A host reaches it over a microprocessor-style bus: active-low chip enable, output enable and write enable, plus an address and a data bus. When the high-voltage-present input is low, the block is a plain read-only memory. When that input is high, bytes written over the bus are decoded as commands. These commands move reads between array data, identifier bytes and verify data. They also start timed erase and program pulses.

Each pulse runs against an internal stop timer, counted in clock cycles. If the timer runs out before the host ends the pulse, the block parks in an inactive state. Only a verify command or a double reset can take it out of that state. The storage is a behavioural register file. It comes out of reset fully erased (every byte FFH). A write cycle is recognised on the clock edge where chip enable is low and write enable has just gone low. A host write therefore holds write enable low across one rising clock edge.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While hvPresent is low, every write is ignored. Reads return the array byte at the bus address, and a running pulse is dropped with no effect on the array.
- R2: A write cycle captures its address. While in program verify or erase verify, reads return the array byte at that captured address, whatever the bus address is.
- R3: An erase starts only when a 20H write is followed by a second 20H write. Any other second write returns to array read and erases nothing.
- R4: An erase sets every byte to FFH when its pulse ends. Writing A0H during the pulse ends it and enters erase verify.
- R5: Writing 00H in any idle state selects array read at the bus address.
- R6: When the stop timer expires, the pulse ends and the block enters an inactive state. There, any write except A0H, C0H or a double FFH is ignored.
- R7: An erase pulse lasts ERASE_CYC cycles and a program pulse lasts PROG_CYC cycles, unless a verify command ends it first. The array is left unchanged until the pulse ends.
- R8: Writing 40H followed by one data write programs that data byte at that write's address when the pulse ends.
- R9: Writing C0H during a program pulse ends the pulse at once, stores the byte, and enters program verify.
- R10: After 90H, reads return MFR_ID at address 0, DEV_ID at address 1 and 00H at every other address.
- R11: Two FFH writes in a row return to array read from any state and abort a running pulse without effect. A single FFH does not stop a pulse.
- R12: A code with no meaning, written in an idle state, returns to array read.
- R13: dataOe is high only when ceN and oeN are low and weN is high; otherwise dataOut is 00H. After reset, every byte reads FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| hvPresent | input | 1 | High programming voltage is present |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Write data / command byte |
| dataOut | output | 8 | Read data, 00H when not driven |
| dataOe | output | 1 | Read data valid / drive enable |

## Verification
The bench targets the cases where a pulse overlaps another write. These are:
- a single FFH during an erase, which must not stop it;
- two FFH writes, which must abort it;
- an early C0H, which must still store the byte exactly once.

A design that treats one FFH as a reset would lose the erase. A design that applies the pulse at its start instead of its end would show erased or programmed data partway through the pulse.

Other targeted cases:
- Writes in the inactive state that must be ignored. A design that leaves that state on any write would answer an identifier request.
- Verify reads at an address other than the captured one. These would expose a read path that follows the bus.
- A second erase byte that is not 20H. A design without the confirm step would wipe the array.
- High voltage dropped in the middle of an erase. This must leave the array intact.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_ID, ST_ERSETUP, ST_ERASING, ST_ERVERIFY,
    ST_PGSETUP, ST_PROGRAMMING, ST_PGVERIFY, ST_INACTIVE
  } state_t;

  typedef enum logic [1:0] {SEL_BUS, SEL_LATCH, SEL_ID} rdsel_t;

  typedef struct packed {
    logic   capture;   // any write cycle: latch address
    logic   progCap;   // program data write: latch program target
    logic   eraseAll;  // erase pulse ends
    logic   progWr;    // program pulse ends
    rdsel_t rdSel;
  } ctrl_stb_t;

  localparam logic [7:0] CODE_READ  = 8'h00;
  localparam logic [7:0] CODE_ERASE = 8'h20;
  localparam logic [7:0] CODE_PROG  = 8'h40;
  localparam logic [7:0] CODE_IDENT = 8'h90;
  localparam logic [7:0] CODE_EVFY  = 8'hA0;
  localparam logic [7:0] CODE_PVFY  = 8'hC0;
  localparam logic [7:0] CODE_RESET = 8'hFF;

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ERASE_CYC = 40,
  parameter int PROG_CYC  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       weN,
  input  logic       hvPresent,
  input  logic [7:0] wrData,
  output ctrl_stb_t  stb,
  output state_t     state
);
  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             weNq;
  logic             ffSeen;
  logic [CNT_W-1:0] cnt;
  state_t           nxt;
  logic             wrPulse, pulsing, expire, ldErase, ldProg, endPulse, dblReset;

  assign wrPulse  = !ceN && !weN && weNq;
  assign pulsing  = (state == ST_ERASING) || (state == ST_PROGRAMMING);
  assign expire   = pulsing && (cnt == CNT_W'(1));
  assign dblReset = wrPulse && ffSeen && (wrData == CODE_RESET);

  always_comb begin
    nxt      = state;
    ldErase  = 1'b0;
    ldProg   = 1'b0;
    endPulse = 1'b0;
    if (!hvPresent) begin
      nxt = ST_READ;
    end else if (dblReset) begin
      nxt = ST_READ;
    end else if (wrPulse) begin
      unique case (state)
        ST_READ, ST_ID, ST_ERVERIFY, ST_PGVERIFY: begin
          unique case (wrData)
            CODE_ERASE: nxt = ST_ERSETUP;
            CODE_PROG:  nxt = ST_PGSETUP;
            CODE_IDENT: nxt = ST_ID;
            CODE_EVFY:  nxt = ST_ERVERIFY;
            CODE_PVFY:  nxt = ST_PGVERIFY;
            default:    nxt = ST_READ;
          endcase
        end
        ST_ERSETUP: begin
          if (wrData == CODE_ERASE) begin
            nxt     = ST_ERASING;
            ldErase = 1'b1;
          end else begin
            nxt = ST_READ;
          end
        end
        ST_PGSETUP: begin
          nxt    = ST_PROGRAMMING;
          ldProg = 1'b1;
        end
        ST_ERASING: if (wrData == CODE_EVFY) begin
          nxt      = ST_ERVERIFY;
          endPulse = 1'b1;
        end
        ST_PROGRAMMING: if (wrData == CODE_PVFY) begin
          nxt      = ST_PGVERIFY;
          endPulse = 1'b1;
        end
        ST_INACTIVE: begin
          if (wrData == CODE_EVFY)      nxt = ST_ERVERIFY;
          else if (wrData == CODE_PVFY) nxt = ST_PGVERIFY;
        end
        default: nxt = ST_READ;
      endcase
    end
    if (hvPresent && expire && (nxt == state)) begin
      nxt      = ST_INACTIVE;
      endPulse = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_READ;
      weNq   <= 1'b1;
      ffSeen <= 1'b0;
      cnt    <= '0;
    end else begin
      state <= nxt;
      weNq  <= weN;
      if (!hvPresent)   ffSeen <= 1'b0;
      else if (wrPulse) ffSeen <= (wrData == CODE_RESET) && !ffSeen;
      if (ldErase)                    cnt <= CNT_W'(ERASE_CYC);
      else if (ldProg)                cnt <= CNT_W'(PROG_CYC);
      else if (pulsing && cnt != '0)  cnt <= cnt - CNT_W'(1);
    end
  end

  always_comb begin
    stb.capture  = wrPulse;
    stb.progCap  = ldProg;
    stb.eraseAll = endPulse && (state == ST_ERASING);
    stb.progWr   = endPulse && (state == ST_PROGRAMMING);
    if (!hvPresent)                                          stb.rdSel = SEL_BUS;
    else if (state == ST_ID)                                 stb.rdSel = SEL_ID;
    else if (state == ST_ERVERIFY || state == ST_PGVERIFY)   stb.rdSel = SEL_LATCH;
    else                                                     stb.rdSel = SEL_BUS;
  end

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W = 4,
  parameter logic [7:0] MFR_ID = 8'h5A,
  parameter logic [7:0] DEV_ID = 8'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_stb_t         stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] latAddr, progAddr;
  logic [7:0]        progData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr  <= '0;
      progAddr <= '0;
      progData <= '0;
    end else begin
      if (stb.capture) latAddr <= busAddr;
      if (stb.progCap) begin
        progAddr <= busAddr;
        progData <= wrData;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                              mem[g] <= 8'hFF;
      else if (stb.eraseAll)                                  mem[g] <= 8'hFF;
      else if (stb.progWr && progAddr == ADDR_W'(g))          mem[g] <= progData;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_ID:    rdData = (busAddr == '0) ? MFR_ID :
                          (busAddr == ADDR_W'(1)) ? DEV_ID : 8'h00;
      SEL_LATCH: rdData = mem[latAddr];
      default:   rdData = mem[busAddr];
    endcase
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W    = 4,
  parameter int         ERASE_CYC = 40,
  parameter int         PROG_CYC  = 10,
  parameter logic [7:0] MFR_ID    = 8'h5A,
  parameter logic [7:0] DEV_ID    = 8'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              hvPresent,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe
);
  ctrl_stb_t  stb;
  state_t     curState;
  logic [7:0] rdData;

  flash_cmd_fsm #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) fsm_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .hvPresent(hvPresent),
    .wrData(dataIn), .stb(stb), .state(curState)
  );

  flash_cmd_dp #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(addr), .wrData(dataIn),
    .rdData(rdData)
  );

  assign dataOe  = !ceN && !oeN && weN;
  assign dataOut = dataOe ? rdData : 8'h00;

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      hvPresent,
  input state_t    curState,
  input ctrl_stb_t stb
);
  assert_hv_lock_R1: assert property (@(posedge clk) disable iff (!rstN)
    !hvPresent |=> curState == ST_READ);

  assert_erase_confirm_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(curState == ST_ERASING) |-> $past(curState) == ST_ERSETUP);

  assert_inactive_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_INACTIVE && $past(curState) != ST_INACTIVE) |->
    ($past(curState) == ST_ERASING || $past(curState) == ST_PROGRAMMING));

  assert_one_pulse_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.eraseAll, stb.progWr}));

  assert_erase_exit_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.eraseAll |=> (curState == ST_INACTIVE || curState == ST_ERVERIFY));

  assert_prog_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.progWr |=> (curState == ST_INACTIVE || curState == ST_PGVERIFY));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .hvPresent(hvPresent), .curState(curState), .stb(stb)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int ECYC   = 40;
  localparam int PCYC   = 10;

  logic clk = 1'b0, rstN = 1'b0, ceN = 1'b1, oeN = 1'b1, weN = 1'b1, hvPresent = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] dataIn = '0, dataOut;
  logic dataOe;
  logic [7:0] exp [DEPTH];
  int nRun = 0, nFail = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .ERASE_CYC(ECYC), .PROG_CYC(PCYC)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .hvPresent(hvPresent),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] expv, input string req);
    nRun++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", req, act, expv);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0; oeN = 1'b1; addr = ADDR_W'(a); dataIn = d;
    @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = ADDR_W'(a);
    #1 d = dataOut;
    check({7'd0, dataOe}, 8'd1, "R13 dataOe during read");
    #1 ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sweep(input string req);
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, v);
      check(v, exp[i], req);
    end
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) exp[i] = 8'hFF;
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R13: reset state and output gating
    #1 check(dataOut, 8'h00, "R13 idle dataOut");
    check({7'd0, dataOe}, 8'd0, "R13 idle dataOe");
    ceN = 1'b0; #1 check({7'd0, dataOe}, 8'd0, "R13 oeN high");
    ceN = 1'b1;
    sweep("R13 reset erased");

    // R10 identifier, R12 unknown code, R5 read mode
    wr(0, 8'h90);
    rd(0, v); check(v, 8'h5A, "R10 manufacturer");
    rd(1, v); check(v, 8'hC3, "R10 device");
    rd(5, v); check(v, 8'h00, "R10 other address");
    wr(0, 8'h55);
    rd(0, v); check(v, exp[0], "R12 unknown code to read");
    wr(0, 8'h90); wr(0, 8'h00);
    rd(1, v); check(v, exp[1], "R5 read after 00H");

    // R8/R6/R2 program sweep with timer expiry
    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] pv;
      pv = 8'((i * 37 + 11) & 255);
      wr(i, 8'h40);
      wr(i, pv);
      rd(i, v); check(v, exp[i], "R7 unchanged during program");
      idle(PCYC + 4);
      exp[i] = pv;
      rd(i, v); check(v, pv, "R8 programmed byte");
      wr(0, 8'h90);
      rd(0, v); check(v, exp[0], "R6 inactive ignores 90H");
      wr(i, 8'hC0);
      rd((i + 5) % DEPTH, v); check(v, pv, "R2 verify uses captured address");
      wr(0, 8'h00);
      rd((i + 5) % DEPTH, v); check(v, exp[(i + 5) % DEPTH], "R5 back to bus address");
    end

    // R9 early verify ends program pulse
    wr(3, 8'h40); wr(3, 8'h3C); wr(3, 8'hC0);
    exp[3] = 8'h3C;
    rd(9, v); check(v, 8'h3C, "R9 early verify stores byte");
    wr(0, 8'h00); idle(PCYC + 4);
    rd(3, v); check(v, 8'h3C, "R9 byte stays");

    // R3 erase needs confirm
    wr(0, 8'h20); wr(0, 8'h00); idle(ECYC + 5);
    sweep("R3 no erase without confirm");
    wr(0, 8'h20); wr(0, 8'h40); wr(2, 8'h77); idle(PCYC + 4);
    rd(2, v); check(v, exp[2], "R3 other second byte aborts");

    // R11 single FFH does not stop erase; R7 min pulse; R4 erase result
    wr(0, 8'h20); wr(0, 8'h20); wr(0, 8'hFF);
    idle(ECYC / 2);
    rd(4, v); check(v, exp[4], "R7 unchanged mid erase");
    idle(ECYC);
    for (int i = 0; i < DEPTH; i++) exp[i] = 8'hFF;
    sweep("R4 erased after timer");
    wr(6, 8'hA0);
    rd(1, v); check(v, 8'hFF, "R4 erase verify read");
    wr(0, 8'h00);

    // R4 A0H ends erase early
    wr(6, 8'h40); wr(6, 8'h12); wr(6, 8'hC0); wr(0, 8'h00);
    rd(6, v); check(v, 8'h12, "R8 program before early erase");
    wr(0, 8'h20); wr(0, 8'h20); wr(6, 8'hA0);
    rd(11, v); check(v, 8'hFF, "R4 early verify erased");

    // R11 double FFH aborts erase
    wr(5, 8'h40); wr(5, 8'h99); wr(5, 8'hC0); wr(0, 8'h00);
    exp[5] = 8'h99;
    wr(0, 8'h20); wr(0, 8'h20); wr(0, 8'hFF); wr(0, 8'hFF);
    idle(ECYC + 5);
    rd(5, v); check(v, 8'h99, "R11 double FFH aborts erase");
    wr(0, 8'h90);
    rd(0, v); check(v, 8'h5A, "R11 reset state accepts commands");
    wr(0, 8'h00);

    // R11 double FFH leaves inactive
    wr(8, 8'h40); wr(8, 8'hAB); idle(PCYC + 4);
    exp[8] = 8'hAB;
    wr(0, 8'hFF); wr(0, 8'hFF); wr(0, 8'h90);
    rd(1, v); check(v, 8'hC3, "R11 reset from inactive");
    wr(0, 8'h00);
    rd(8, v); check(v, 8'hAB, "R8 byte from expired pulse");

    // R1 no high voltage
    hvPresent = 1'b0;
    wr(0, 8'h20); wr(0, 8'h20); idle(ECYC + 5);
    wr(2, 8'h40); wr(2, 8'h00); idle(PCYC + 4);
    wr(0, 8'h90);
    rd(0, v); check(v, exp[0], "R1 identifier locked out");
    sweep("R1 writes ignored");
    hvPresent = 1'b1;
    wr(0, 8'h20); wr(0, 8'h20); idle(5);
    hvPresent = 1'b0; idle(ECYC + 5);
    hvPresent = 1'b1;
    rd(5, v); check(v, 8'h99, "R1 dropped erase has no effect");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule